// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block keeps the control state that software uses to drive a two-channel bus-master DMA engine. Each channel has three registers: a command byte, a status byte and a 32-bit descriptor-table pointer. Writes arrive on a simple single-port register bus. Each write carries a channel select, a register select and a width flag (byte or dword). A global bus-master-enable input gates every write. Reads are combinational and have no side effects.

Toggling the start/stop bit of a command register sends a one-cycle event to the DMA engine. A rising edge gives a start pulse, and the engine samples that channel's pointer output alongside it. A falling edge gives an abort pulse. When the engine finishes, it returns a per-channel completion pulse. That pulse stops the channel and raises its interrupt flag. Descriptor fetch and data movement are handled elsewhere.

Top module: `bm_dma_regs`

## Requirements
- R1: After reset, every command register and every pointer reads 0 and every status register reads 0x60 (the drive-capable bits 5 and 6 are set). No start or abort pulse is present.
- R2: Command layout: bit 0 is start/stop and bit 3 is direction. While start/stop is 1, a command write keeps the old direction bit. All other command bits take the written value.
- R3: A command write that takes start/stop from 0 to 1 sets status bit 0 (active). In the cycle after the write it raises that channel's start pulse for exactly one cycle, and the pointer output for that channel holds the descriptor-table pointer.
- R4: A command write that takes start/stop from 1 to 0 clears the active bit and gives a one-cycle abort pulse in the following cycle.
- R5: A status write never changes the active bit (bit 0).
- R6: Status bit 1 (error) and bit 2 (interrupt) clear only when they are 1 and a 1 is written to them. A write never sets either bit.
- R7: A pointer write must be a dword, and it stores the data with bits 1:0 forced to 0. A byte-wide pointer write is ignored.
- R8: A dword-wide write to a command or status register is ignored.
- R9: A completion pulse for a channel clears start/stop and active and sets interrupt, with no abort pulse. A command or status write to that channel in the same cycle is dropped.
- R10: While bus-master enable is 0, every write is ignored. Completion pulses still apply.
- R11: Status bits 3 through 7 take the written value on a byte status write.
- R12: Register select values are 0 for command, 1 for status and 2 for pointer. Select 3 reads 0 and ignores writes. Reads of any register leave all state unchanged, and the two channels never affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bm_en_i | input | 1 | Bus-master enable; gates all writes |
| wr_en_i | input | 1 | Write strobe |
| wr_chan_i | input | CH_W | Write channel |
| wr_sel_i | input | 2 | Write register select |
| wr_dword_i | input | 1 | 1 = dword write, 0 = byte write |
| wr_data_i | input | 32 | Write data (byte writes use bits 7:0) |
| rd_chan_i | input | CH_W | Read channel |
| rd_sel_i | input | 2 | Read register select |
| rd_data_o | output | 32 | Read data, zero-extended |
| done_i | input | NUM_CH | Per-channel completion pulse from the engine |
| start_o | output | NUM_CH | Per-channel start pulse |
| abort_o | output | NUM_CH | Per-channel abort pulse |
| start_ptr_o | output | NUM_CH*PTR_W | Per-channel descriptor-table pointers, channel 0 in the low bits |

## Verification
The assertions rely on the engine never raising a completion pulse together with a start on the same channel. They also assume the register bus presents at most one write per cycle, so a status write cannot coincide with a start or abort event. The stimulus uses a single write port by construction. It raises completion pulses at random, independent of channel state. Those pulses can land on idle channels or in the same cycle as a write to the same channel, which exercises the precedence rule. Bus-master enable is dropped in about a tenth of the cycles.

// File: rtl/bm_dma_pkg.sv
package bm_dma_pkg;
  localparam int CMD_SS  = 0;
  localparam int CMD_DIR = 3;
  localparam int STS_ACT = 1 - 1;
  localparam int STS_ERR = 1;
  localparam int STS_INT = 2;
  localparam logic [7:0] STS_RST = 8'h60;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STS  = 2'd1,
    SEL_PTR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/bm_dma_cmd.sv
module bm_dma_cmd
  import bm_dma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       done_i,
  output logic [7:0] cmd_o,
  output logic       start_evt_o,
  output logic       abort_evt_o
);
  logic [7:0] cmd_q, cand;
  logic       wr_eff;

  // completion wins over a same-cycle write
  assign wr_eff = wr_i && !done_i;

  always_comb begin
    cand = wdata_i;
    if (cmd_q[CMD_SS]) cand[CMD_DIR] = cmd_q[CMD_DIR];
  end

  assign start_evt_o = wr_eff && !cmd_q[CMD_SS] &&  cand[CMD_SS];
  assign abort_evt_o = wr_eff &&  cmd_q[CMD_SS] && !cand[CMD_SS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_q <= '0;
    else if (done_i) cmd_q[CMD_SS] <= 1'b0;
    else if (wr_eff) cmd_q <= cand;
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/bm_dma_sts.sv
module bm_dma_sts
  import bm_dma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       start_evt_i,
  input  logic       abort_evt_i,
  input  logic       done_i,
  output logic [7:0] sts_o
);
  logic [7:0] sts_q, sts_d, wval;

  always_comb begin
    wval          = wdata_i;
    wval[STS_ACT] = sts_q[STS_ACT];
    wval[STS_ERR] = sts_q[STS_ERR] && !wdata_i[STS_ERR];
    wval[STS_INT] = sts_q[STS_INT] && !wdata_i[STS_INT];

    sts_d = sts_q;
    if (done_i) begin
      sts_d[STS_ACT] = 1'b0;
      sts_d[STS_INT] = 1'b1;
    end else begin
      if (wr_i)        sts_d = wval;
      if (start_evt_i) sts_d[STS_ACT] = 1'b1;
      if (abort_evt_i) sts_d[STS_ACT] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= STS_RST;
    else         sts_q <= sts_d;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/bm_dma_ptr.sv
module bm_dma_ptr #(
  parameter int PTR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [PTR_W-1:0] wdata_i,
  output logic [PTR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_o <= '0;
    else if (wr_i) ptr_o <= {wdata_i[PTR_W-1:2], 2'b00};
  end
endmodule

// File: rtl/bm_dma_regs.sv
module bm_dma_regs
  import bm_dma_pkg::*;
#(
  parameter  int NUM_CH = 2,
  parameter  int PTR_W  = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bm_en_i,
  input  logic                    wr_en_i,
  input  logic [CH_W-1:0]         wr_chan_i,
  input  logic [1:0]              wr_sel_i,
  input  logic                    wr_dword_i,
  input  logic [PTR_W-1:0]        wr_data_i,
  input  logic [CH_W-1:0]         rd_chan_i,
  input  logic [1:0]              rd_sel_i,
  output logic [PTR_W-1:0]        rd_data_o,
  input  logic [NUM_CH-1:0]       done_i,
  output logic [NUM_CH-1:0]       start_o,
  output logic [NUM_CH-1:0]       abort_o,
  output logic [NUM_CH*PTR_W-1:0] start_ptr_o
);
  logic [NUM_CH-1:0][7:0]       cmd_q, sts_q;
  logic [NUM_CH-1:0][PTR_W-1:0] ptr_q;
  logic [NUM_CH-1:0]            start_evt, abort_evt;
  logic                         wr_ok;

  assign wr_ok = wr_en_i && bm_en_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit, wr_cmd, wr_sts, wr_ptr;
    assign hit    = wr_ok && (wr_chan_i == CH_W'(c));
    assign wr_cmd = hit && (wr_sel_i == SEL_CMD) && !wr_dword_i;
    assign wr_sts = hit && (wr_sel_i == SEL_STS) && !wr_dword_i && !done_i[c];
    assign wr_ptr = hit && (wr_sel_i == SEL_PTR) &&  wr_dword_i;

    bm_dma_cmd u_cmd (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr_cmd),
      .wdata_i     (wr_data_i[7:0]),
      .done_i      (done_i[c]),
      .cmd_o       (cmd_q[c]),
      .start_evt_o (start_evt[c]),
      .abort_evt_o (abort_evt[c])
    );

    bm_dma_sts u_sts (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr_sts),
      .wdata_i     (wr_data_i[7:0]),
      .start_evt_i (start_evt[c]),
      .abort_evt_i (abort_evt[c]),
      .done_i      (done_i[c]),
      .sts_o       (sts_q[c])
    );

    bm_dma_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_ptr),
      .wdata_i (wr_data_i),
      .ptr_o   (ptr_q[c])
    );

    assign start_ptr_o[c*PTR_W +: PTR_W] = ptr_q[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= '0;
      abort_o <= '0;
    end else begin
      start_o <= start_evt;
      abort_o <= abort_evt;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (32'(rd_chan_i) < NUM_CH) begin
      case (rd_sel_i)
        SEL_CMD: rd_data_o = PTR_W'(cmd_q[rd_chan_i]);
        SEL_STS: rd_data_o = PTR_W'(sts_q[rd_chan_i]);
        SEL_PTR: rd_data_o = ptr_q[rd_chan_i];
        default: rd_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/bm_dma_regs_chk.sv
module bm_dma_regs_chk #(
  parameter int NUM_CH = 2,
  parameter int PTR_W  = 32
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         bm_en_i,
  input logic [NUM_CH-1:0]            done_i,
  input logic [NUM_CH-1:0]            start_o,
  input logic [NUM_CH-1:0]            abort_o,
  input logic [NUM_CH-1:0][7:0]       cmd_q,
  input logic [NUM_CH-1:0][7:0]       sts_q,
  input logic [NUM_CH-1:0][PTR_W-1:0] ptr_q
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_dir_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(cmd_q[c][0]) && cmd_q[c][0]) |-> (cmd_q[c][3] == $past(cmd_q[c][3])));

    assert_start_active_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o[c] |-> (sts_q[c][0] && cmd_q[c][0] && !$past(cmd_q[c][0])));

    assert_start_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o[c] |=> !start_o[c]);

    assert_abort_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_o[c] |-> (!sts_q[c][0] && !cmd_q[c][0] && !start_o[c]));

    assert_int_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sts_q[c][2]) |-> $past(done_i[c]));

    assert_err_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$rose(sts_q[c][1]));

    assert_ptr_align_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ptr_q[c][1:0] == 2'b00);

    assert_done_update_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[c] |=> (!cmd_q[c][0] && !sts_q[c][0] && sts_q[c][2] && !abort_o[c]));

    assert_bm_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!bm_en_i && !done_i[c]) |=>
        ($stable(cmd_q[c]) && $stable(sts_q[c]) && $stable(ptr_q[c])));
  end
endmodule

bind bm_dma_regs bm_dma_regs_chk #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .bm_en_i (bm_en_i),
  .done_i  (done_i),
  .start_o (start_o),
  .abort_o (abort_o),
  .cmd_q   (cmd_q),
  .sts_q   (sts_q),
  .ptr_q   (ptr_q)
);

// File: tb/bm_dma_regs_test.sv
module bm_dma_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bm_en = 1'b0, wr_en = 1'b0, wr_chan = 1'b0, wr_dword = 1'b0, rd_chan = 1'b0;
  logic [1:0]  wr_sel = 2'd0, rd_sel = 2'd0, done = 2'b00;
  logic [31:0] wr_data = '0, rd_data;
  logic [1:0]  start, abort;
  logic [63:0] start_ptr;

  int compared = 0, mismatched = 0;
  logic [7:0]  m_cmd [2];
  logic [7:0]  m_sts [2];
  logic [31:0] m_ptr [2];
  logic [1:0]  e_start, e_abort;

  always #5 clk = ~clk;

  bm_dma_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .bm_en_i(bm_en), .wr_en_i(wr_en),
    .wr_chan_i(wr_chan), .wr_sel_i(wr_sel), .wr_dword_i(wr_dword),
    .wr_data_i(wr_data), .rd_chan_i(rd_chan), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .done_i(done), .start_o(start), .abort_o(abort),
    .start_ptr_o(start_ptr)
  );

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] sts_write(logic [7:0] old, logic [7:0] d);
    logic [7:0] n;
    n    = d;
    n[0] = old[0];
    n[1] = old[1] & ~d[1];
    n[2] = old[2] & ~d[2];
    return n;
  endfunction

  task automatic check_all(string tag);
    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < 4; s++) begin
        rd_chan = c[0];
        rd_sel  = s[1:0];
        #1;
        case (s)
          0: cmp(tag, $sformatf("cmd ch%0d", c), 64'(rd_data), 64'(m_cmd[c]));
          1: cmp(tag, $sformatf("sts ch%0d", c), 64'(rd_data), 64'(m_sts[c]));
          2: cmp(tag, $sformatf("ptr ch%0d", c), 64'(rd_data), 64'(m_ptr[c]));
          default: cmp(tag, "sel3 read", 64'(rd_data), 64'd0);
        endcase
      end
    end
  endtask

  // one bus cycle: drive at negedge, check pulses and all registers after the edge
  task automatic step(string tag, logic bm, logic we, logic ch, logic [1:0] sel,
                      logic dw, logic [31:0] d, logic [1:0] dn);
    logic [7:0] n;
    @(negedge clk);
    bm_en = bm; wr_en = we; wr_chan = ch; wr_sel = sel; wr_dword = dw;
    wr_data = d; done = dn;
    e_start = 2'b00; e_abort = 2'b00;
    if (bm && we && !dn[ch]) begin
      if (sel == 2'd0 && !dw) begin
        n = d[7:0];
        if (m_cmd[ch][0]) n[3] = m_cmd[ch][3];
        if (!m_cmd[ch][0] && n[0]) begin e_start[ch] = 1'b1; m_sts[ch][0] = 1'b1; end
        if (m_cmd[ch][0] && !n[0]) begin e_abort[ch] = 1'b1; m_sts[ch][0] = 1'b0; end
        m_cmd[ch] = n;
      end else if (sel == 2'd1 && !dw) begin
        m_sts[ch] = sts_write(m_sts[ch], d[7:0]);
      end
    end
    if (bm && we && sel == 2'd2 && dw) m_ptr[ch] = {d[31:2], 2'b00};
    for (int c = 0; c < 2; c++) begin
      if (dn[c]) begin
        m_cmd[c][0] = 1'b0;
        m_sts[c][0] = 1'b0;
        m_sts[c][2] = 1'b1;
      end
    end
    @(posedge clk);
    #2;
    wr_en = 1'b0; done = 2'b00;
    cmp(tag, "start pulse (R3)", 64'(start), 64'(e_start));
    cmp(tag, "abort pulse (R4)", 64'(abort), 64'(e_abort));
    for (int c = 0; c < 2; c++)
      if (e_start[c]) cmp(tag, "start ptr R3", 64'(start_ptr[c*32 +: 32]), 64'(m_ptr[c]));
    check_all(tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < 2; c++) begin
      m_cmd[c] = 8'h00; m_sts[c] = 8'h60; m_ptr[c] = 32'h0;
    end
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    cmp("R1", "start after reset", 64'(start), 64'd0);
    cmp("R1", "abort after reset", 64'(abort), 64'd0);
    check_all("R1");
    @(negedge clk); rst_n = 1'b1;

    // R7 pointer: dword stores with low bits cleared, byte ignored
    step("R7", 1, 1, 0, 2'd2, 1, 32'hDEAD_BEEF, 2'b00);
    step("R7", 1, 1, 0, 2'd2, 0, 32'h1234_5678, 2'b00);
    step("R7", 1, 1, 1, 2'd2, 1, 32'h0000_1003, 2'b00);
    // R3 start with direction bit set
    step("R3", 1, 1, 0, 2'd0, 0, 32'h09, 2'b00);
    // R2 direction frozen while running, other bits still written
    step("R2", 1, 1, 0, 2'd0, 0, 32'h11, 2'b00);
    // R5 and R11 status write while active
    step("R5", 1, 1, 0, 2'd1, 0, 32'h98, 2'b00);
    step("R11", 1, 1, 0, 2'd1, 0, 32'h00, 2'b00);
    // R8 dword command write ignored
    step("R8", 1, 1, 0, 2'd0, 1, 32'h0, 2'b00);
    step("R8", 1, 1, 0, 2'd1, 1, 32'hFF, 2'b00);
    // R4 abort
    step("R4", 1, 1, 0, 2'd0, 0, 32'h00, 2'b00);
    step("R2", 1, 1, 0, 2'd0, 0, 32'h00, 2'b00);
    // R9 completion with same-cycle command write dropped
    step("R3", 1, 1, 1, 2'd0, 0, 32'h01, 2'b00);
    step("R9", 1, 1, 1, 2'd0, 0, 32'h00, 2'b10);
    // R6 interrupt: writing 0 keeps it, writing 1 clears, writing 1 again cannot set
    step("R6", 1, 1, 1, 2'd1, 0, 32'h00, 2'b00);
    step("R6", 1, 1, 1, 2'd1, 0, 32'h04, 2'b00);
    step("R6", 1, 1, 1, 2'd1, 0, 32'h06, 2'b00);
    // R10 writes ignored with bus mastering off, completion still lands
    step("R10", 0, 1, 0, 2'd0, 0, 32'h01, 2'b00);
    step("R10", 0, 1, 0, 2'd2, 1, 32'hFFFF_FFF0, 2'b01);
    // R12 select 3 write ignored, repeated reads have no side effects
    step("R12", 1, 1, 0, 2'd3, 1, 32'hFFFF_FFFF, 2'b00);
    check_all("R12");

    for (int i = 0; i < 600; i++) begin
      logic [1:0] sel;
      logic       dw;
      string      tag;
      sel = 2'($urandom_range(0, 3));
      dw  = (sel == 2'd2) ? ($urandom_range(0, 7) != 0) : ($urandom_range(0, 7) == 0);
      tag = (sel == 2'd0) ? "R2" : (sel == 2'd1) ? "R6" : (sel == 2'd2) ? "R7" : "R12";
      step(tag, $urandom_range(0, 9) != 0, $urandom_range(0, 4) != 0,
           1'($urandom), sel, dw, $urandom,
           {($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0)});
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule